// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the configuration state of a processor's system control coprocessor. The core hands it a coprocessor transfer instruction word on a single access port, with a strobe and a direction bit. The block pulls a primary register number and a secondary selector out of that word. A write updates the selected register. A read returns the register contents one cycle later.

Beyond plain storage, some selections return fixed identification values. Some writes fire a one-cycle flush request toward the address-translation cache. Selections that are reserved or unsupported raise an undefined-register flag, so the core can take an undefined-instruction trap. The control, translation-base, domain-access and process-offset values are driven straight out as ports for the memory-management logic.

Top module: `sysctl_regfile`

## Requirements
- R1: After synchronous reset every writable register reads as zero, and `ctrl_o`, `tbase_o`, `dom_o`, `pid_off_o`, `rdata_o`, `rvld_o`, `undef_o` and `xlat_flush_o` are all zero.
- R2: The primary number is taken from `insn_i[19:16]` and the secondary from `insn_i[7:5]`; all other instruction bits are ignored. A read strobe gives `rvld_o`=1 and the read value on `rdata_o` in the following cycle; in any other cycle `rdata_o` is zero.
- R3: A write to primary 1, secondary 0 loads the control register (visible on `ctrl_o` the next cycle) and pulses `xlat_flush_o` for one cycle, one cycle after the strobe.
- R4: For primary 5 (fault status) and primary 6 (fault address), secondary 0 selects the data-side register and secondary 1 the instruction-side register; both are readable and writable; any other secondary is undefined.
- R5: A read of primary 0 returns 0x01DD20D2 for secondary 1, zero for secondary 2 and the `dev_id_i` value for any other secondary; every write to primary 0 is undefined.
- R6: A write to primary 8 with secondary 0 or 1 pulses `xlat_flush_o`; other secondaries of a write, and every read of primary 8, are undefined.
- R7: Primaries 4, 11, 12 and 14 are undefined for read and write. An undefined access changes no register, gives no flush, and an undefined read returns zero.
- R8: Primary 13 secondary 0 is the process address offset (driven on `pid_off_o`) and secondary 1 the context ID; both are readable and writable.
- R9: Reads of primaries 7, 10 and 15 return zero. Writes to them are accepted: they are not undefined, they give no flush, and they change no register.
- R10: A read of primary 1, secondary 1 returns 1 when `aux_feat_i` is set and is undefined when it is clear; a write to it is always undefined.
- R11: Primaries 2 (translation base, `tbase_o`) and 3 (domain access, `dom_o`) are read/write for any secondary. Primary 9 secondaries 0/1 are data/instruction lockdown registers. Primary 1 secondary 2 is the coprocessor access register.
- R12: `undef_o` is high for exactly the cycle after an undefined access and `rvld_o` only for the cycle after a read; with no strobe both are zero the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id_i | input | 32 | Static device identification value |
| aux_feat_i | input | 1 | Auxiliary-control feature present |
| acc_vld_i | input | 1 | Access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| insn_i | input | 32 | Coprocessor transfer instruction word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvld_o | output | 1 | Read data valid |
| undef_o | output | 1 | Undefined-register flag |
| xlat_flush_o | output | 1 | Translation-cache flush pulse |
| ctrl_o | output | 32 | Control register |
| tbase_o | output | 32 | Translation base register |
| dom_o | output | 32 | Domain access register |
| pid_off_o | output | 32 | Process address offset |

## Verification
Every register is loaded with a distinct value, so a swapped data/instruction pair or a wrong primary decode shows up as a wrong value on readback. The instruction words carry set bits outside the two selector fields, which exposes a decoder that looks at the wrong bits. Each primary is tried for both read and write across in-range and out-of-range secondaries, which separates undefined, ignored and flushing selections. The auxiliary read is tried with the feature input both clear and set. A reference model predicts all outputs after every access and idle cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Index of every writable register in the storage array.
  typedef enum logic [3:0] {
    WR_CTRL   = 4'd0,
    WR_CPACC  = 4'd1,
    WR_TBASE  = 4'd2,
    WR_DOM    = 4'd3,
    WR_FSR_D  = 4'd4,
    WR_FSR_I  = 4'd5,
    WR_FAR_D  = 4'd6,
    WR_FAR_I  = 4'd7,
    WR_LK_D   = 4'd8,
    WR_LK_I   = 4'd9,
    WR_PIDOFF = 4'd10,
    WR_CTXID  = 4'd11
  } widx_e;

  localparam int NREG = 12;

  // Where read data comes from.
  typedef enum logic [2:0] {
    SRC_ZERO  = 3'd0,
    SRC_REG   = 3'd1,
    SRC_DEVID = 3'd2,
    SRC_CTYPE = 3'd3,
    SRC_ONE   = 3'd4
  } rsrc_e;

  typedef struct packed {
    logic  undef;
    logic  flush;
    logic  use_reg;
    rsrc_e src;
    widx_e idx;
  } dec_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int IW      = 32,
  parameter int PRI_LSB = 16,
  parameter int SEC_LSB = 5
) (
  input  logic [IW-1:0] insn_i,
  input  logic          wr_i,
  input  logic          aux_feat_i,
  output dec_t          dec_o
);

  logic [3:0] pri;
  logic [2:0] sec;

  assign pri = insn_i[PRI_LSB +: 4];
  assign sec = insn_i[SEC_LSB +: 3];

  always_comb begin
    dec_o.undef   = 1'b0;
    dec_o.flush   = 1'b0;
    dec_o.use_reg = 1'b0;
    dec_o.src     = SRC_ZERO;
    dec_o.idx     = WR_CTRL;
    unique case (pri)
      4'd0: begin
        if (wr_i) dec_o.undef = 1'b1;
        else if (sec == 3'd1) dec_o.src = SRC_CTYPE;
        else if (sec == 3'd2) dec_o.src = SRC_ZERO;
        else dec_o.src = SRC_DEVID;
      end
      4'd1: begin
        if (sec == 3'd0) begin
          dec_o.use_reg = 1'b1;
          dec_o.idx     = WR_CTRL;
          dec_o.flush   = wr_i;
        end else if (sec == 3'd2) begin
          dec_o.use_reg = 1'b1;
          dec_o.idx     = WR_CPACC;
        end else if (sec == 3'd1 && !wr_i && aux_feat_i) begin
          dec_o.src = SRC_ONE;
        end else begin
          dec_o.undef = 1'b1;
        end
      end
      4'd2: begin
        dec_o.use_reg = 1'b1;
        dec_o.idx     = WR_TBASE;
      end
      4'd3: begin
        dec_o.use_reg = 1'b1;
        dec_o.idx     = WR_DOM;
      end
      4'd5, 4'd6, 4'd9, 4'd13: begin
        if (sec > 3'd1) begin
          dec_o.undef = 1'b1;
        end else begin
          dec_o.use_reg = 1'b1;
          case (pri)
            4'd5:    dec_o.idx = sec[0] ? WR_FSR_I : WR_FSR_D;
            4'd6:    dec_o.idx = sec[0] ? WR_FAR_I : WR_FAR_D;
            4'd9:    dec_o.idx = sec[0] ? WR_LK_I  : WR_LK_D;
            default: dec_o.idx = sec[0] ? WR_CTXID : WR_PIDOFF;
          endcase
        end
      end
      4'd7, 4'd10, 4'd15: begin
        dec_o.src = SRC_ZERO;
      end
      4'd8: begin
        if (!wr_i || sec > 3'd1) dec_o.undef = 1'b1;
        else dec_o.flush = 1'b1;
      end
      default: begin
        dec_o.undef = 1'b1;
      end
    endcase
    if (dec_o.use_reg) dec_o.src = SRC_REG;
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int DW   = 32,
  parameter int NREG = 12,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [AW-1:0]            idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  q_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q_o[g] <= '0;
      else if (we_i && idx_i == AW'(g)) q_o[g] <= wdata_i;
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          IW      = 32,
  parameter int          PRI_LSB = 16,
  parameter int          SEC_LSB = 5,
  parameter logic [31:0] CTYPE   = 32'h01DD20D2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dev_id_i,
  input  logic          aux_feat_i,
  input  logic          acc_vld_i,
  input  logic          acc_wr_i,
  input  logic [IW-1:0] insn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvld_o,
  output logic          undef_o,
  output logic          xlat_flush_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] tbase_o,
  output logic [DW-1:0] dom_o,
  output logic [DW-1:0] pid_off_o
);

  localparam int AW = $clog2(NREG);

  dec_t                    dec;
  logic [NREG-1:0][DW-1:0] regs;
  logic                    we;
  logic [DW-1:0]           rmux;

  sysctl_decode #(.IW(IW), .PRI_LSB(PRI_LSB), .SEC_LSB(SEC_LSB)) u_dec (
    .insn_i     (insn_i),
    .wr_i       (acc_wr_i),
    .aux_feat_i (aux_feat_i),
    .dec_o      (dec)
  );

  assign we = acc_vld_i && acc_wr_i && dec.use_reg && !dec.undef;

  sysctl_store #(.DW(DW), .NREG(NREG)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we_i    (we),
    .idx_i   (AW'(dec.idx)),
    .wdata_i (wdata_i),
    .q_o     (regs)
  );

  always_comb begin
    unique case (dec.src)
      SRC_REG:   rmux = regs[dec.idx];
      SRC_DEVID: rmux = dev_id_i;
      SRC_CTYPE: rmux = DW'(CTYPE);
      SRC_ONE:   rmux = DW'(1);
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o      <= '0;
      rvld_o       <= 1'b0;
      undef_o      <= 1'b0;
      xlat_flush_o <= 1'b0;
    end else begin
      rvld_o       <= acc_vld_i && !acc_wr_i;
      undef_o      <= acc_vld_i && dec.undef;
      xlat_flush_o <= acc_vld_i && acc_wr_i && dec.flush && !dec.undef;
      rdata_o      <= (acc_vld_i && !acc_wr_i && !dec.undef) ? rmux : '0;
    end
  end

  assign ctrl_o    = regs[WR_CTRL];
  assign tbase_o   = regs[WR_TBASE];
  assign dom_o     = regs[WR_DOM];
  assign pid_off_o = regs[WR_PIDOFF];

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int          DW      = 32,
  parameter int          IW      = 32,
  parameter int          PRI_LSB = 16,
  parameter int          SEC_LSB = 5,
  parameter logic [31:0] CTYPE   = 32'h01DD20D2
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_vld_i,
  input logic          acc_wr_i,
  input logic [IW-1:0] insn_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvld_o,
  input logic          undef_o,
  input logic          xlat_flush_o,
  input logic [DW-1:0] ctrl_o,
  input logic [DW-1:0] pid_off_o
);

  logic [3:0] p;
  logic [2:0] s;
  assign p = insn_i[PRI_LSB +: 4];
  assign s = insn_i[SEC_LSB +: 3];

  // R3
  ctrl_write_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && acc_wr_i && p == 4'd1 && s == 3'd0)
      |=> (xlat_flush_o && ctrl_o == $past(wdata_i)));

  // R5
  cache_type_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && !acc_wr_i && p == 4'd0 && s == 3'd1)
      |=> (rvld_o && rdata_o == DW'(CTYPE)));

  // R7
  reserved_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && (p == 4'd4 || p == 4'd11 || p == 4'd12 || p == 4'd14))
      |=> (undef_o && !xlat_flush_o && $stable(ctrl_o)));

  // R8
  pid_offset_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && acc_wr_i && p == 4'd13 && s == 3'd0)
      |=> (pid_off_o == $past(wdata_i)));

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && acc_wr_i && (p == 4'd7 || p == 4'd10 || p == 4'd15))
      |=> (!undef_o && !xlat_flush_o && $stable(ctrl_o)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld_i |=> (!rvld_o && !undef_o && !xlat_flush_o));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .DW(DW), .IW(IW), .PRI_LSB(PRI_LSB), .SEC_LSB(SEC_LSB), .CTYPE(CTYPE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_vld_i    (acc_vld_i),
  .acc_wr_i     (acc_wr_i),
  .insn_i       (insn_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .rvld_o       (rvld_o),
  .undef_o      (undef_o),
  .xlat_flush_o (xlat_flush_o),
  .ctrl_o       (ctrl_o),
  .pid_off_o    (pid_off_o)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dev_id = 32'h4106_9265;
  logic        aux = 1'b0;
  logic        vld = 1'b0;
  logic        wrb = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdata, ctrl, tbase, dom, pidoff;
  logic        rvld, undef, flush;

  always #2.5 clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rst(rst), .dev_id_i(dev_id), .aux_feat_i(aux),
    .acc_vld_i(vld), .acc_wr_i(wrb), .insn_i(insn), .wdata_i(wdat),
    .rdata_o(rdata), .rvld_o(rvld), .undef_o(undef), .xlat_flush_o(flush),
    .ctrl_o(ctrl), .tbase_o(tbase), .dom_o(dom), .pid_off_o(pidoff)
  );

  int checks = 0;
  int failures = 0;

  // Reference model state
  logic [31:0] m_ctrl, m_cpacc, m_tb, m_dom;
  logic [31:0] m_fs [2];
  logic [31:0] m_fa [2];
  logic [31:0] m_lk [2];
  logic [31:0] m_pid [2];
  logic [31:0] e_rdata;
  logic        e_rvld, e_undef, e_flush;

  task automatic model_clear();
    m_ctrl = 0; m_cpacc = 0; m_tb = 0; m_dom = 0;
    for (int i = 0; i < 2; i++) begin
      m_fs[i] = 0; m_fa[i] = 0; m_lk[i] = 0; m_pid[i] = 0;
    end
    e_rdata = 0; e_rvld = 0; e_undef = 0; e_flush = 0;
  endtask

  task automatic model_step(input bit wr, input int p, input int s, input logic [31:0] d);
    bit u = 0;
    bit fl = 0;
    logic [31:0] r = 0;
    int k = s & 1;
    case (p)
      0: if (wr) u = 1; else r = (s == 1) ? 32'h01DD20D2 : (s == 2) ? 32'h0 : dev_id;
      1: begin
        if (s == 0) begin if (wr) begin m_ctrl = d; fl = 1; end else r = m_ctrl; end
        else if (s == 2) begin if (wr) m_cpacc = d; else r = m_cpacc; end
        else if (s == 1 && !wr && aux) r = 1;
        else u = 1;
      end
      2: if (wr) m_tb = d; else r = m_tb;
      3: if (wr) m_dom = d; else r = m_dom;
      5: if (s > 1) u = 1; else if (wr) m_fs[k] = d; else r = m_fs[k];
      6: if (s > 1) u = 1; else if (wr) m_fa[k] = d; else r = m_fa[k];
      9: if (s > 1) u = 1; else if (wr) m_lk[k] = d; else r = m_lk[k];
      13: if (s > 1) u = 1; else if (wr) m_pid[k] = d; else r = m_pid[k];
      7, 10, 15: r = 0;
      8: if (!wr || s > 1) u = 1; else fl = 1;
      default: u = 1;
    endcase
    e_rvld  = !wr;
    e_undef = u;
    e_flush = fl;
    e_rdata = (wr || u) ? 32'h0 : r;
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic compare(input string rq);
    chk(rq, "rdata", rdata, e_rdata);
    chk(rq, "rvld", {31'b0, rvld}, {31'b0, e_rvld});
    chk(rq, "undef", {31'b0, undef}, {31'b0, e_undef});
    chk(rq, "flush", {31'b0, flush}, {31'b0, e_flush});
    chk(rq, "ctrl", ctrl, m_ctrl);
    chk(rq, "tbase", tbase, m_tb);
    chk(rq, "dom", dom, m_dom);
    chk(rq, "pidoff", pidoff, m_pid[0]);
  endtask

  // Noise bits outside 19:16 and 7:5 must not matter (R2).
  function automatic logic [31:0] mk(input int p, input int s);
    return 32'hE0E0_0F10 | (32'(p) << 16) | (32'(s) << 5);
  endfunction

  task automatic access(input bit wr, input int p, input int s, input logic [31:0] d, input string rq);
    @(negedge clk);
    vld = 1; wrb = wr; insn = mk(p, s); wdat = d;
    model_step(wr, p, s, d);
    @(negedge clk);
    vld = 0; wrb = 0; insn = 0; wdat = 0;
    compare(rq);
  endtask

  task automatic idle(input string rq);
    @(negedge clk);
    e_rdata = 0; e_rvld = 0; e_undef = 0; e_flush = 0;
    compare(rq);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst = 0;
    compare("R1");
    access(0, 2, 0, 0, "R1");
    access(0, 5, 1, 0, "R1");
    access(0, 13, 1, 0, "R1");
    access(0, 9, 0, 0, "R1");

    // R5 identification
    access(0, 0, 0, 0, "R5");
    access(0, 0, 1, 0, "R5");
    access(0, 0, 2, 0, "R5");
    access(0, 0, 7, 0, "R5");
    access(1, 0, 0, 32'hFFFF_FFFF, "R5");

    // R3 control
    access(1, 1, 0, 32'h0000_3005, "R3");
    access(0, 1, 0, 0, "R3");
    idle("R12");

    // R11 base, domain, lockdown, coproc access
    access(1, 2, 3, 32'hABCD_4000, "R11");
    access(1, 3, 6, 32'h5555_0003, "R11");
    access(0, 2, 0, 0, "R11");
    access(0, 3, 1, 0, "R11");
    access(1, 1, 2, 32'h0C00_0000, "R11");
    access(0, 1, 2, 0, "R11");
    access(1, 9, 0, 32'h1111_0001, "R11");
    access(1, 9, 1, 32'h2222_0002, "R11");
    access(0, 9, 0, 0, "R11");
    access(0, 9, 1, 0, "R11");
    access(1, 9, 2, 32'hDEAD_0009, "R11");

    // R4 fault status and address
    access(1, 5, 0, 32'h0000_00F5, "R4");
    access(1, 5, 1, 32'h0000_0017, "R4");
    access(1, 6, 0, 32'hC000_1234, "R4");
    access(1, 6, 1, 32'hC000_5678, "R4");
    access(1, 5, 2, 32'hBAD0_BAD0, "R4");
    access(0, 6, 3, 0, "R4");
    access(0, 5, 0, 0, "R4");
    access(0, 5, 1, 0, "R4");
    access(0, 6, 0, 0, "R4");
    access(0, 6, 1, 0, "R4");

    // R6 translation invalidate
    access(1, 8, 0, 0, "R6");
    access(1, 8, 1, 32'h1234_5000, "R6");
    access(1, 8, 3, 0, "R6");
    access(0, 8, 0, 0, "R6");

    // R7 reserved primaries
    access(1, 4, 0, 32'hFFFF_FFFF, "R7");
    access(0, 4, 0, 0, "R7");
    access(1, 11, 0, 32'hFFFF_FFFF, "R7");
    access(0, 12, 1, 0, "R7");
    access(1, 14, 0, 32'hFFFF_FFFF, "R7");
    access(0, 14, 0, 0, "R7");
    access(0, 1, 0, 0, "R7");

    // R8 process ID
    access(1, 13, 0, 32'h0200_0000, "R8");
    access(1, 13, 1, 32'h0000_00A5, "R8");
    access(0, 13, 0, 0, "R8");
    access(0, 13, 1, 0, "R8");

    // R9 ignored primaries
    access(1, 7, 0, 32'hFFFF_FFFF, "R9");
    access(1, 10, 0, 32'hFFFF_FFFF, "R9");
    access(1, 15, 3, 32'hFFFF_FFFF, "R9");
    access(0, 7, 0, 0, "R9");
    access(0, 10, 0, 0, "R9");
    access(0, 15, 5, 0, "R9");

    // R10 auxiliary read
    access(0, 1, 1, 0, "R10");
    @(negedge clk); aux = 1;
    access(0, 1, 1, 0, "R10");
    access(1, 1, 1, 32'h1, "R10");
    access(0, 1, 3, 0, "R10");

    // R12 flags drop after an undefined access
    access(0, 4, 0, 0, "R12");
    idle("R12");
    idle("R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule